// File: doc/BRIEF.md
# SD Host Programmed-I/O Register Block

This block is the processor-facing register file of an SD host controller that moves data by programmed I/O. Software loads an argument, a transfer mode and a block count. It then writes a 16-bit command word. When the block accepts that word, it hands the command and argument to a card-side command engine with a one-cycle start pulse. The engine answers with a completion pulse and a 128-bit response. The block latches the response and exposes it as four consecutive 32-bit registers.

Commands that move data go through a single internal buffer of one block, `BUF_BYTES` bytes (512 by default). The host reaches it through a 32-bit data port. In the card-to-host direction, the engine fills the buffer and the host then empties it word by word. In the host-to-card direction, the host fills the buffer and the engine then drains it. Interrupt-status flags tell software when a command has finished, when the buffer is ready to read or write, and when the whole transfer is over. The flags are cleared by writing one to them. A two-bit present-state register shows whether the command path and the data path are busy.

All register accesses are whole 32-bit words at word offsets. Read data appears on `bus_rdata` in the cycle after the read strobe.

Top module: `sdh_pio_regs`

## Requirements
- R1: Registers sit at these word offsets: 0 command, 1 argument, 2 transfer mode, 3 block size, 4 block count, 5 data port, 6 present state, 7 interrupt status, 8 to 11 response. After reset all of them read 0, except block size, which reads `BUF_BYTES`. Writes to mode, block size and block count read back as their low 16 bits. Read data is valid one cycle after the read strobe.
- R2: An accepted command write has these effects. It stores the low 16 bits as the command. One cycle later it raises `eng_start` for exactly one cycle, with `eng_cmd` and `eng_arg` holding the command and the argument. It sets command-inhibit, which is present-state bit 0.
- R3: A command write is ignored while command-inhibit is set. A data command (flag bits [1:0] == 2'b11) is also ignored while data-inhibit (present-state bit 1) is set. A command without data is still accepted while only data-inhibit is set.
- R4: A write to the argument register while command-inhibit is set leaves the argument unchanged.
- R5: An `eng_done` pulse while command-inhibit is set has three effects. It captures `eng_resp` with bits [32k+31:32k] readable at offset 8+k. It clears command-inhibit. It sets interrupt-status bit 0 (command complete).
- R6: Writing the interrupt-status register clears each bit written as 1 and leaves bits written as 0. Only bits 0, 1, 4 and 5 can ever read as 1.
- R7: Accepting a data command sets data-inhibit. Data-inhibit clears, and interrupt-status bit 1 (transfer done) sets, in the cycle where the last word of the last block leaves the buffer.
- R8: The transfer moves the block-count number of blocks when mode bit 5 (multi-block) and mode bit 1 (count enable) are both set; a count of 0 counts as 1. Otherwise the transfer moves exactly one block.
- R9: With mode bit 4 set (card-to-host), the engine pushes words while `eng_fill_ready` is high. Once a full block has been pushed, `eng_fill_ready` drops and interrupt-status bit 5 (read ready) sets. Host reads of offset 5 then return the words in push order.
- R10: With mode bit 4 clear (host-to-card), interrupt-status bit 4 (write ready) sets whenever the buffer is empty and blocks remain, including at command acceptance. Host writes to offset 5 fill the buffer. Once it is full, `eng_drain_valid` rises and `eng_drain_data` presents the words in write order, one per `eng_drain_ready` cycle.
- R11: A read of the data port while the host is not in the buffer-drain phase returns 0 and consumes no buffer word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| eng_start | output | 1 | One-cycle command start toward the engine |
| eng_cmd | output | 16 | Command word held for the engine |
| eng_arg | output | 32 | Command argument |
| eng_mode | output | 16 | Transfer-mode register, including auto stop (bit 2) |
| eng_done | input | 1 | Engine command completion pulse |
| eng_resp | input | 128 | Engine response, valid with `eng_done` |
| eng_fill_valid | input | 1 | Engine offers a card-to-host word |
| eng_fill_data | input | 32 | Card-to-host word |
| eng_fill_ready | output | 1 | Buffer accepts card-to-host words |
| eng_drain_valid | output | 1 | Buffer offers a host-to-card word |
| eng_drain_data | output | 32 | Host-to-card word |
| eng_drain_ready | input | 1 | Engine takes the offered word |

## Verification
The bench builds the block with `BUF_BYTES` = 32, so a block is eight data-port words. At that size every last-word boundary comes up many times in a short run: the read-ready and write-ready events, the return to the engine phase between blocks, and the final transfer-done cycle. These include a two-block host-to-card transfer and a multi-block mode without count enable. `ADDR_W` stays at its default of 4, which covers the whole register map.

// File: rtl/sdh_pio_pkg.sv
// Package: shared register offsets, bit positions and phase type for the
// SD host programmed-I/O register block. Assumes word-addressed accesses.
package sdh_pio_pkg;

    // Word offsets of the register map
    localparam int REG_CMD   = 0;
    localparam int REG_ARG   = 1;
    localparam int REG_MODE  = 2;
    localparam int REG_BSIZE = 3;
    localparam int REG_BCNT  = 4;
    localparam int REG_DATA  = 5;
    localparam int REG_STATE = 6;
    localparam int REG_IRQ   = 7;
    localparam int REG_RESP0 = 8;

    // Interrupt-status bit positions
    localparam int IRQ_CMD_DONE  = 0;
    localparam int IRQ_XFER_DONE = 1;
    localparam int IRQ_WR_RDY    = 4;
    localparam int IRQ_RD_RDY    = 5;

    // Transfer-mode bit positions
    localparam int MODE_CNT_EN = 1;
    localparam int MODE_DIR_RD = 4;
    localparam int MODE_MULTI  = 5;

    // Data-buffer ownership phases
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ENG_FILL,
        PH_HOST_DRAIN,
        PH_HOST_FILL,
        PH_ENG_DRAIN
    } xfer_phase_e;

    // A command uses the data line when both low flag bits are set
    function automatic logic uses_data(input logic [1:0] flags);
        return flags == 2'b11;
    endfunction

endpackage

// File: rtl/sdh_cmd_path.sv
// Module: command path. Holds the argument, command word, command-inhibit
// flag and captured response; issues the one-cycle start to the engine.
// Assumes the engine pulses eng_done once per started command.
module sdh_cmd_path
    import sdh_pio_pkg::*;
#(
    parameter int RESP_WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_arg,
    input  logic                     wr_cmd,
    input  logic [31:0]              wdata,
    input  logic                     dat_inhibit,
    input  logic                     eng_done,
    input  logic [32*RESP_WORDS-1:0] eng_resp,
    output logic [31:0]              arg_q,
    output logic [15:0]              cmd_q,
    output logic                     cmd_inhibit,
    output logic [32*RESP_WORDS-1:0] resp_q,
    output logic                     eng_start,
    output logic                     data_cmd_go,
    output logic                     cmd_done
);

    logic cmd_ok;

    // Acceptance rule for a command write
    always_comb begin
        cmd_ok      = wr_cmd && !cmd_inhibit &&
                      !(uses_data(wdata[1:0]) && dat_inhibit);
        data_cmd_go = cmd_ok && uses_data(wdata[1:0]);
        cmd_done    = eng_done && cmd_inhibit;
    end

    // Argument register, frozen while a command is in flight
    always_ff @(posedge clk) begin
        if (!rst_n)                      arg_q <= '0;
        else if (wr_arg && !cmd_inhibit) arg_q <= wdata;
    end

    // Command word, inhibit flag and start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            cmd_inhibit <= 1'b0;
            eng_start   <= 1'b0;
        end else begin
            eng_start <= cmd_ok;
            if (cmd_ok) begin
                cmd_q       <= wdata[15:0];
                cmd_inhibit <= 1'b1;
            end else if (eng_done) begin
                cmd_inhibit <= 1'b0;
            end
        end
    end

    // Response capture, one register per 32-bit word
    for (genvar w = 0; w < RESP_WORDS; w++) begin : g_resp
        always_ff @(posedge clk) begin
            if (!rst_n)        resp_q[32*w +: 32] <= '0;
            else if (cmd_done) resp_q[32*w +: 32] <= eng_resp[32*w +: 32];
        end
    end

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> cmd_inhibit);
    assert_arg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_inhibit |=> $stable(arg_q));
    assert_done_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_inhibit);

endmodule

// File: rtl/sdh_xfer_buf.sv
// Module: single-block data buffer and transfer sequencer. Tracks which side
// owns the buffer, counts words and blocks, raises ready and done events.
// Assumes BUF_BYTES is a power of two of at least 8.
module sdh_xfer_buf
    import sdh_pio_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             dir_rd,
    input  logic             multi_cnt,
    input  logic [CNT_W-1:0] blk_count,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    input  logic             fill_valid,
    input  logic [31:0]      fill_data,
    output logic             fill_ready,
    output logic             drain_valid,
    output logic [31:0]      drain_data,
    input  logic             drain_ready,
    output logic             dat_inhibit,
    output logic             evt_rd_rdy,
    output logic             evt_wr_rdy,
    output logic             evt_done
);

    localparam int WORDS = BUF_BYTES / 4;
    localparam int IW    = $clog2(WORDS);
    localparam logic [IW-1:0]    LAST = IW'(WORDS - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    xfer_phase_e      phase;
    logic [IW-1:0]    ptr;
    logic [CNT_W-1:0] blocks_left;
    logic [CNT_W-1:0] start_blocks;
    logic [31:0]      mem [WORDS];
    logic             wr_step, rd_step, last_word, last_blk;
    logic [31:0]      wr_word;

    // Step decode, ready flags and events
    always_comb begin
        last_word    = (ptr == LAST);
        last_blk     = (blocks_left == ONE);
        fill_ready   = (phase == PH_ENG_FILL);
        drain_valid  = (phase == PH_ENG_DRAIN);
        dat_inhibit  = (phase != PH_IDLE);
        wr_step      = (fill_ready && fill_valid) ||
                       (phase == PH_HOST_FILL && host_wr);
        rd_step      = (phase == PH_HOST_DRAIN && host_rd) ||
                       (drain_valid && drain_ready);
        wr_word      = fill_ready ? fill_data : host_wdata;
        start_blocks = (multi_cnt && blk_count != '0) ? blk_count : ONE;
        host_rdata   = (phase == PH_HOST_DRAIN) ? mem[ptr] : 32'h0;
        drain_data   = mem[ptr];
        evt_rd_rdy   = fill_ready && fill_valid && last_word;
        evt_wr_rdy   = (go && !dir_rd) ||
                       (drain_valid && drain_ready && last_word && !last_blk);
        evt_done     = rd_step && last_word && last_blk;
    end

    // Buffer storage write port
    always_ff @(posedge clk) begin
        if (wr_step) mem[ptr] <= wr_word;
    end

    // Phase, word pointer and block counter sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            ptr         <= '0;
            blocks_left <= '0;
        end else if (go) begin
            phase       <= dir_rd ? PH_ENG_FILL : PH_HOST_FILL;
            ptr         <= '0;
            blocks_left <= start_blocks;
        end else if (wr_step) begin
            if (last_word) begin
                ptr   <= '0;
                phase <= (phase == PH_ENG_FILL) ? PH_HOST_DRAIN : PH_ENG_DRAIN;
            end else begin
                ptr <= ptr + IW'(1);
            end
        end else if (rd_step) begin
            if (last_word) begin
                ptr         <= '0;
                blocks_left <= blocks_left - ONE;
                if (last_blk)                    phase <= PH_IDLE;
                else if (phase == PH_HOST_DRAIN) phase <= PH_ENG_FILL;
                else                             phase <= PH_HOST_FILL;
            end else begin
                ptr <= ptr + IW'(1);
            end
        end
    end

    assert_one_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_ready && drain_valid));
    assert_done_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !dat_inhibit);
    assert_full_stops_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd_rdy |=> !fill_ready);
    assert_go_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !dat_inhibit);

endmodule

// File: rtl/sdh_irq_stat.sv
// Module: interrupt-status register with sticky set events and
// write-one-to-clear. Bits outside IMPL_MASK are held at zero.
module sdh_irq_stat #(
    parameter int             W         = 16,
    parameter logic [W-1:0]   IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] set_evt,
    output logic [W-1:0] status
);

    logic [W-1:0] clr_eff;

    // Clear mask applies only on a register write
    always_comb clr_eff = clr_wr ? clr_mask : '0;

    // Sticky status, set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= ((status & ~clr_eff) | set_evt) & IMPL_MASK;
    end

    assert_event_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_evt & IMPL_MASK)) |=>
        ((status & $past(set_evt & IMPL_MASK)) == $past(set_evt & IMPL_MASK)));
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && ((set_evt & clr_mask) == '0)) |=> ((status & $past(clr_mask)) == '0));

endmodule

// File: rtl/sdh_pio_regs.sv
// Module: top of the SD host programmed-I/O register block. Decodes word
// accesses, holds the mode/size/count registers, muxes registered read data
// and wires the command path, data buffer and interrupt status together.
// Assumes single-cycle strobes and whole-word accesses.
module sdh_pio_regs
    import sdh_pio_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_start,
    output logic [15:0]       eng_cmd,
    output logic [31:0]       eng_arg,
    output logic [15:0]       eng_mode,
    input  logic              eng_done,
    input  logic [127:0]      eng_resp,
    input  logic              eng_fill_valid,
    input  logic [31:0]       eng_fill_data,
    output logic              eng_fill_ready,
    output logic              eng_drain_valid,
    output logic [31:0]       eng_drain_data,
    input  logic              eng_drain_ready
);

    localparam int RESP_WORDS = 4;
    localparam int CNT_W      = 16;
    localparam int IRQ_W      = 16;
    localparam logic [IRQ_W-1:0] IRQ_IMPL =
        IRQ_W'((1 << IRQ_CMD_DONE) | (1 << IRQ_XFER_DONE) |
               (1 << IRQ_WR_RDY)   | (1 << IRQ_RD_RDY));

    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(REG_CMD);
    localparam logic [ADDR_W-1:0] A_ARG   = ADDR_W'(REG_ARG);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(REG_MODE);
    localparam logic [ADDR_W-1:0] A_BSIZE = ADDR_W'(REG_BSIZE);
    localparam logic [ADDR_W-1:0] A_BCNT  = ADDR_W'(REG_BCNT);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(REG_DATA);
    localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(REG_STATE);
    localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(REG_IRQ);

    logic [15:0]             mode_q, bsize_q;
    logic [CNT_W-1:0]        bcnt_q;
    logic [31:0]             arg_q, host_rdata, rd_mux;
    logic [15:0]             cmd_q;
    logic [32*RESP_WORDS-1:0] resp_q;
    logic                    cmd_inhibit, dat_inhibit, data_cmd_go, cmd_done;
    logic                    evt_rd_rdy, evt_wr_rdy, evt_done;
    logic [IRQ_W-1:0]        irq_status, irq_set;
    logic                    wr_arg, wr_cmd, wr_irq, wr_data, rd_data;

    // Write and data-port strobes per register
    always_comb begin
        wr_arg  = bus_wr && bus_addr == A_ARG;
        wr_cmd  = bus_wr && bus_addr == A_CMD;
        wr_irq  = bus_wr && bus_addr == A_IRQ;
        wr_data = bus_wr && bus_addr == A_DATA;
        rd_data = bus_rd && bus_addr == A_DATA;
    end

    // Transfer-mode, block-size and block-count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            bsize_q <= 16'(BUF_BYTES);
            bcnt_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MODE)  mode_q  <= bus_wdata[15:0];
            if (bus_addr == A_BSIZE) bsize_q <= bus_wdata[15:0];
            if (bus_addr == A_BCNT)  bcnt_q  <= bus_wdata[CNT_W-1:0];
        end
    end

    sdh_cmd_path #(.RESP_WORDS(RESP_WORDS)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_arg      (wr_arg),
        .wr_cmd      (wr_cmd),
        .wdata       (bus_wdata),
        .dat_inhibit (dat_inhibit),
        .eng_done    (eng_done),
        .eng_resp    (eng_resp),
        .arg_q       (arg_q),
        .cmd_q       (cmd_q),
        .cmd_inhibit (cmd_inhibit),
        .resp_q      (resp_q),
        .eng_start   (eng_start),
        .data_cmd_go (data_cmd_go),
        .cmd_done    (cmd_done)
    );

    sdh_xfer_buf #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (data_cmd_go),
        .dir_rd      (mode_q[MODE_DIR_RD]),
        .multi_cnt   (mode_q[MODE_MULTI] && mode_q[MODE_CNT_EN]),
        .blk_count   (bcnt_q),
        .host_wr     (wr_data),
        .host_rd     (rd_data),
        .host_wdata  (bus_wdata),
        .host_rdata  (host_rdata),
        .fill_valid  (eng_fill_valid),
        .fill_data   (eng_fill_data),
        .fill_ready  (eng_fill_ready),
        .drain_valid (eng_drain_valid),
        .drain_data  (eng_drain_data),
        .drain_ready (eng_drain_ready),
        .dat_inhibit (dat_inhibit),
        .evt_rd_rdy  (evt_rd_rdy),
        .evt_wr_rdy  (evt_wr_rdy),
        .evt_done    (evt_done)
    );

    // Gather interrupt set events into their bit positions
    always_comb begin
        irq_set                = '0;
        irq_set[IRQ_CMD_DONE]  = cmd_done;
        irq_set[IRQ_XFER_DONE] = evt_done;
        irq_set[IRQ_WR_RDY]    = evt_wr_rdy;
        irq_set[IRQ_RD_RDY]    = evt_rd_rdy;
    end

    sdh_irq_stat #(.W(IRQ_W), .IMPL_MASK(IRQ_IMPL)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_wr   (wr_irq),
        .clr_mask (bus_wdata[IRQ_W-1:0]),
        .set_evt  (irq_set),
        .status   (irq_status)
    );

    // Read multiplexer over the register map
    always_comb begin
        rd_mux = 32'h0;
        case (bus_addr)
            A_CMD:   rd_mux = {16'h0, cmd_q};
            A_ARG:   rd_mux = arg_q;
            A_MODE:  rd_mux = {16'h0, mode_q};
            A_BSIZE: rd_mux = {16'h0, bsize_q};
            A_BCNT:  rd_mux = {{(32-CNT_W){1'b0}}, bcnt_q};
            A_DATA:  rd_mux = host_rdata;
            A_STATE: rd_mux = {30'h0, dat_inhibit, cmd_inhibit};
            A_IRQ:   rd_mux = {{(32-IRQ_W){1'b0}}, irq_status};
            default: rd_mux = 32'h0;
        endcase
        for (int w = 0; w < RESP_WORDS; w++) begin
            if (bus_addr == ADDR_W'(REG_RESP0 + w)) rd_mux = resp_q[32*w +: 32];
        end
    end

    // Registered read data, updated on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // Engine-facing copies of the command registers
    always_comb begin
        eng_cmd  = cmd_q;
        eng_arg  = arg_q;
        eng_mode = mode_q;
    end

    assert_busy_blocks_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && cmd_inhibit) |=> $stable(cmd_q));

endmodule

// File: tb/sim_sdh_pio_regs.sv
`timescale 1ns/1ps
module sim_sdh_pio_regs;

    localparam int BUF_BYTES = 32;
    localparam int WORDS     = BUF_BYTES / 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_wr, bus_rd;
    logic [3:0]   bus_addr;
    logic [31:0]  bus_wdata, bus_rdata;
    logic         eng_start, eng_done;
    logic [15:0]  eng_cmd, eng_mode;
    logic [31:0]  eng_arg;
    logic [127:0] eng_resp;
    logic         eng_fill_valid, eng_fill_ready;
    logic [31:0]  eng_fill_data;
    logic         eng_drain_valid, eng_drain_ready;
    logic [31:0]  eng_drain_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic        rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    sdh_pio_regs #(.BUF_BYTES(BUF_BYTES), .ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_cmd(eng_cmd), .eng_arg(eng_arg),
        .eng_mode(eng_mode), .eng_done(eng_done), .eng_resp(eng_resp),
        .eng_fill_valid(eng_fill_valid), .eng_fill_data(eng_fill_data),
        .eng_fill_ready(eng_fill_ready), .eng_drain_valid(eng_drain_valid),
        .eng_drain_data(eng_drain_data), .eng_drain_ready(eng_drain_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compares each registered read result with the queued expectation
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) chk("read with no expectation", bus_rdata, 32'hx);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: queue the expected value, then issue the read
    task automatic rd_exp(input int a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = 4'(a);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic eng_finish(input logic [127:0] r);
        eng_done = 1'b1; eng_resp = r;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic eng_fill(input logic [31:0] base);
        for (int i = 0; i < WORDS; i++) begin
            eng_fill_valid = 1'b1; eng_fill_data = base + 32'(i);
            @(negedge clk);
        end
        eng_fill_valid = 1'b0;
    endtask

    task automatic eng_drain(input logic [31:0] base, input string tag);
        for (int i = 0; i < WORDS; i++) begin
            chk(tag, {31'h0, eng_drain_valid}, 32'h1);
            chk(tag, eng_drain_data, base + 32'(i));
            eng_drain_ready = 1'b1;
            @(negedge clk);
        end
        eng_drain_ready = 1'b0;
    endtask

    task automatic host_fill(input logic [31:0] base);
        for (int i = 0; i < WORDS; i++) wr(5, base + 32'(i));
    endtask

    task automatic host_read(input logic [31:0] base, input string tag);
        for (int i = 0; i < WORDS; i++) rd_exp(5, base + 32'(i), tag);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        eng_done = 1'b0; eng_resp = '0; eng_fill_valid = 1'b0; eng_fill_data = '0;
        eng_drain_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values and plain read-back
        rd_exp(0, 32'h0, "R1 cmd reset");
        rd_exp(6, 32'h0, "R1 state reset");
        rd_exp(7, 32'h0, "R1 irq reset");
        rd_exp(3, 32'(BUF_BYTES), "R1 block size reset");
        rd_exp(2, 32'h0, "R1 mode reset");
        wr(3, 32'h0000_0200); rd_exp(3, 32'h200, "R1 block size");
        wr(4, 32'h0001_0003); rd_exp(4, 32'h3, "R1 block count");
        wr(1, 32'h1234_5678); rd_exp(1, 32'h1234_5678, "R1 argument");

        // R2: command issue toward the engine
        wr(0, 32'h0000_371A);
        chk("R2 start pulse", {31'h0, eng_start}, 32'h1);
        chk("R2 engine command", {16'h0, eng_cmd}, 32'h371A);
        chk("R2 engine argument", eng_arg, 32'h1234_5678);
        rd_exp(6, 32'h1, "R2 command inhibit");
        chk("R2 start ends", {31'h0, eng_start}, 32'h0);
        // R4 and R3: writes while busy
        wr(1, 32'hDEAD_BEEF); rd_exp(1, 32'h1234_5678, "R4 argument frozen");
        wr(0, 32'h0000_0D1A); rd_exp(0, 32'h371A, "R3 command while busy");
        // R5: response capture
        eng_finish({32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001});
        rd_exp(6, 32'h0, "R5 inhibit cleared");
        rd_exp(7, 32'h1, "R5 command complete");
        rd_exp(8, 32'h1111_0001, "R5 response word 0");
        rd_exp(9, 32'h2222_0002, "R5 response word 1");
        rd_exp(10, 32'h3333_0003, "R5 response word 2");
        rd_exp(11, 32'h4444_0004, "R5 response word 3");
        // R6: write-one-to-clear
        wr(7, 32'h0); rd_exp(7, 32'h1, "R6 zero keeps bit");
        wr(7, 32'hFFFF_FFFF); rd_exp(7, 32'h0, "R6 one clears bit");

        // R9 / R7: single block card-to-host
        wr(2, 32'h10);
        wr(0, 32'h1123);
        rd_exp(6, 32'h3, "R7 data inhibit set");
        eng_finish('0); wr(7, 32'h1);
        rd_exp(6, 32'h2, "R7 data inhibit held");
        wr(0, 32'h1823); rd_exp(0, 32'h1123, "R3 data command blocked");
        wr(0, 32'h0D1A); rd_exp(6, 32'h3, "R3 plain command accepted");
        eng_finish('0); wr(7, 32'h1);
        rd_exp(5, 32'h0, "R11 early data read");
        chk("R9 fill ready", {31'h0, eng_fill_ready}, 32'h1);
        eng_fill(32'hC0DE_0000);
        chk("R9 fill ready drops", {31'h0, eng_fill_ready}, 32'h0);
        rd_exp(7, 32'h20, "R9 read ready");
        host_read(32'hC0DE_0000, "R9 data order");
        rd_exp(7, 32'h22, "R7 transfer done");
        rd_exp(6, 32'h0, "R7 data inhibit cleared");
        wr(7, 32'h22); rd_exp(7, 32'h0, "R6 clear both");

        // R10 / R8: two blocks host-to-card with count enabled
        wr(4, 32'h2); wr(2, 32'h22);
        wr(0, 32'h1923);
        rd_exp(7, 32'h10, "R10 write ready at start");
        eng_finish('0); wr(7, 32'h11);
        chk("R10 no drain before full", {31'h0, eng_drain_valid}, 32'h0);
        host_fill(32'hB000_0000);
        eng_drain(32'hB000_0000, "R10 drain first block");
        rd_exp(7, 32'h10, "R10 write ready again");
        rd_exp(6, 32'h2, "R8 second block pending");
        wr(7, 32'h10);
        host_fill(32'hB100_0000);
        eng_drain(32'hB100_0000, "R10 drain second block");
        rd_exp(7, 32'h02, "R8 done after count");
        rd_exp(6, 32'h0, "R8 idle after count");
        wr(7, 32'h02);

        // R8: multi-block without count enable moves one block
        wr(4, 32'h5); wr(2, 32'h30);
        wr(0, 32'h1223);
        eng_finish('0); wr(7, 32'h1);
        eng_fill(32'hA000_0000);
        host_read(32'hA000_0000, "R8 single block data");
        rd_exp(6, 32'h0, "R8 single block only");
        rd_exp(7, 32'h22, "R8 single block flags");
        wr(7, 32'h22);

        // R11: idle data port
        rd_exp(5, 32'h0, "R11 idle data read");
        rd_exp(6, 32'h0, "R11 state untouched");

        @(negedge clk);
        @(negedge clk);
        summary();
    end

endmodule